// File: doc/BRIEF.md
# Interrupt Vectoring and Return Controller

This block sits beside an instruction fetch unit. It takes five interrupt request lines and arbitrates them at instruction boundaries. Each line has its own enable and its own priority bit, and a global enable gates all of them. When it accepts a request, it saves the current 16-bit program counter on a byte-wide stack in memory, low byte first. It then issues a one-cycle redirect to the fixed vector of the winning source. The vectors start at address 3 and are spaced eight bytes apart.

A return strobe reverses the save. The block reads the two bytes back, issues a one-cycle resume with the restored program counter, and clears the in-service flag of the priority level being left. There are two levels. A high-level request can interrupt a low-level routine. Any other request waits until the in-service flag that blocks it has been cleared. Saving other registers is left to software.

The stack pointer lives inside the block. The stack memory sits outside it and is reached through a write port and a read port. The read port has one cycle of latency.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the stack pointer is 0x07, both in-service bits are 0, `ctrl_busy` is 0, and `stk_we`, `stk_re`, `redirect_valid` and `resume_valid` are all 0.
- R2: Source k vectors to 3 + 8*k. That gives 0x03, 0x0B, 0x13, 0x1B and 0x23 for k = 0 to 4. `redirect_valid` is high for exactly one cycle: the third cycle after the clock edge that sampled the accepted request. The bit of the accepted level in `in_service` (bit 0 low, bit 1 high) is set in that same cycle.
- R3: An accepted request writes the stack with the stack pointer pre-incremented each time. In the first cycle after the accepting edge, it writes the low byte of `pc_now` at SP+1. In the next cycle, it writes the high byte at SP+2. The stack pointer ends 2 higher.
- R4: A request is ignored when `irq_glob_en` is 0 or its bit in `irq_src_en` is 0. In that case there is no stack write, no redirect, and the stack pointer does not change.
- R5: A request is sampled only in a cycle where `insn_boundary` is 1. A request held without a boundary strobe has no effect.
- R6: Among requests eligible at the same level, the lowest source index wins.
- R7: A high-level request (its bit in `irq_src_hi` is 1) is accepted while only a low-level routine is in service. Afterwards both in-service bits are 1.
- R8: A low-level request is not accepted while either in-service bit is set. A high-level request is not accepted while the high in-service bit is set.
- R9: A return strobe causes two reads: the first at SP, the second at SP-1, in consecutive cycles starting the cycle after the strobe edge. `resume_valid` pulses in the fourth cycle after the strobe edge. `resume_pc` is {byte at SP, byte at SP-1}, and the stack pointer ends 2 lower.
- R10: A return clears only the highest set in-service bit. A request that was held off by the cleared level can then be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 5 | Interrupt request lines, level sampled |
| irq_glob_en | input | 1 | Global interrupt enable |
| irq_src_en | input | 5 | Per-source enables |
| irq_src_hi | input | 5 | Per-source priority, 1 = high level |
| insn_boundary | input | 1 | Instruction boundary strobe |
| retn_strobe | input | 1 | Return-from-interrupt strobe |
| pc_now | input | 16 | Program counter to save on acceptance |
| stk_we | output | 1 | Stack write enable |
| stk_waddr | output | 8 | Stack write address |
| stk_wdata | output | 8 | Stack write byte |
| stk_re | output | 1 | Stack read enable |
| stk_raddr | output | 8 | Stack read address |
| stk_rdata | input | 8 | Stack read byte, one cycle after `stk_re` |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 16 | Vector address |
| resume_valid | output | 1 | One-cycle resume strobe after return |
| resume_pc | output | 16 | Restored program counter |
| in_service | output | 2 | In-service flags, bit 1 high level |
| ctrl_busy | output | 1 | Push or pop sequence in progress |
| sp_now | output | 8 | Current stack pointer |

## Verification
The bench nests a high-level routine inside a low-level one and then unwinds both. A design that cleared both in-service bits on the first return, or popped the bytes in the wrong order, would resume at the wrong address or let the held-off low request in too early. Same-level and lower-level requests are presented while a routine is in service to catch a controller that lets a routine re-enter itself. Several simultaneous requests check that the lowest index wins at each level. Requests masked by either enable, and requests held without a boundary strobe, must leave the stack pointer and stack port quiet.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned LVL_N = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_JUMP,
    ST_POP_A,
    ST_POP_B,
    ST_POP_C
  } ivc_state_e;
endpackage

// File: rtl/ivc_pick.sv
module ivc_pick #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ivc_vector.sv
module ivc_vector #(
  parameter int N        = 5,
  parameter int PC_W     = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0]   idx,
  output logic [PC_W-1:0] vec
);
  always_comb vec = PC_W'(VEC_BASE + int'(idx) * VEC_STEP);
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter import ivc_pkg::*; #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     hi_sel,
  input  logic             set_en,
  input  logic             set_lvl,
  input  logic             clr_en,
  output logic             grant_valid,
  output logic             grant_lvl,
  output logic [IW-1:0]    grant_idx,
  output logic [LVL_N-1:0] insv
);
  logic [LVL_N-1:0][N-1:0]  lvl_req;
  logic [LVL_N-1:0]         lvl_any;
  logic [LVL_N-1:0][IW-1:0] lvl_idx;
  logic [LVL_N-1:0]         insv_q;

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    if (g == LVL_N - 1) begin : g_high
      assign lvl_req[g] = pend & hi_sel;
    end else begin : g_low
      assign lvl_req[g] = pend & ~hi_sel;
    end
    ivc_pick #(.N(N)) u_pick (
      .req (lvl_req[g]),
      .any (lvl_any[g]),
      .idx (lvl_idx[g])
    );
  end

  always_comb begin
    grant_valid = 1'b0;
    grant_lvl   = 1'b0;
    grant_idx   = '0;
    if (lvl_any[1] && !insv_q[1]) begin
      grant_valid = 1'b1;
      grant_lvl   = 1'b1;
      grant_idx   = lvl_idx[1];
    end else if (lvl_any[0] && (insv_q == '0)) begin
      grant_valid = 1'b1;
      grant_idx   = lvl_idx[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insv_q <= '0;
    end else begin
      if (set_en) insv_q[set_lvl] <= 1'b1;
      if (clr_en) begin
        if (insv_q[1]) insv_q[1] <= 1'b0;
        else           insv_q[0] <= 1'b0;
      end
    end
  end

  assign insv = insv_q;

  // R8: a level is never entered while it is already in service
  a_r8_no_reentry: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !insv_q[set_lvl]);

  // R10: one return never drops both levels at once
  a_r10_single_clear: assert property (@(posedge clk) disable iff (rst)
    !($fell(insv_q[0]) && $fell(insv_q[1])));

  // R7: low level only becomes active while high is idle
  a_r7_low_under_high: assert property (@(posedge clk) disable iff (rst)
    $rose(insv_q[0]) |-> !$past(insv_q[1]));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import ivc_pkg::*; #(
  parameter int N_SRC    = 5,
  parameter int BYTE_W   = 8,
  parameter int SP_W     = 8,
  parameter int SP_INIT  = 7,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int PC_W = 2 * BYTE_W,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              irq_glob_en,
  input  logic [N_SRC-1:0]  irq_src_en,
  input  logic [N_SRC-1:0]  irq_src_hi,
  input  logic              insn_boundary,
  input  logic              retn_strobe,
  input  logic [PC_W-1:0]   pc_now,
  output logic              stk_we,
  output logic [SP_W-1:0]   stk_waddr,
  output logic [BYTE_W-1:0] stk_wdata,
  output logic              stk_re,
  output logic [SP_W-1:0]   stk_raddr,
  input  logic [BYTE_W-1:0] stk_rdata,
  output logic              redirect_valid,
  output logic [PC_W-1:0]   redirect_pc,
  output logic              resume_valid,
  output logic [PC_W-1:0]   resume_pc,
  output logic [LVL_N-1:0]  in_service,
  output logic              ctrl_busy,
  output logic [SP_W-1:0]   sp_now
);
  ivc_state_e        state_q;
  logic [SP_W-1:0]   sp_q;
  logic [BYTE_W-1:0] pc_hi_q;
  logic [BYTE_W-1:0] pop_hi_q;
  logic [IW-1:0]     idx_q;
  logic              lvl_q;

  logic [N_SRC-1:0]  pend;
  logic              grant_valid;
  logic              grant_lvl;
  logic [IW-1:0]     grant_idx;
  logic [PC_W-1:0]   vec_addr;

  assign pend = irq_req & irq_src_en & {N_SRC{irq_glob_en}};

  ivc_arbiter #(.N(N_SRC)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .pend        (pend),
    .hi_sel      (irq_src_hi),
    .set_en      (state_q == ST_JUMP),
    .set_lvl     (lvl_q),
    .clr_en      (state_q == ST_POP_C),
    .grant_valid (grant_valid),
    .grant_lvl   (grant_lvl),
    .grant_idx   (grant_idx),
    .insv        (in_service)
  );

  ivc_vector #(
    .N(N_SRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_vec (
    .idx (idx_q),
    .vec (vec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      sp_q           <= SP_W'(SP_INIT);
      pc_hi_q        <= '0;
      pop_hi_q       <= '0;
      idx_q          <= '0;
      lvl_q          <= 1'b0;
      stk_we         <= 1'b0;
      stk_waddr      <= '0;
      stk_wdata      <= '0;
      stk_re         <= 1'b0;
      stk_raddr      <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      resume_valid   <= 1'b0;
      resume_pc      <= '0;
    end else begin
      redirect_valid <= 1'b0;
      resume_valid   <= 1'b0;
      stk_we         <= 1'b0;
      stk_re         <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (retn_strobe) begin
            stk_re    <= 1'b1;
            stk_raddr <= sp_q;
            sp_q      <= sp_q - SP_W'(1);
            state_q   <= ST_POP_A;
          end else if (insn_boundary && grant_valid) begin
            idx_q     <= grant_idx;
            lvl_q     <= grant_lvl;
            pc_hi_q   <= pc_now[PC_W-1:BYTE_W];
            stk_we    <= 1'b1;
            stk_waddr <= sp_q + SP_W'(1);
            stk_wdata <= pc_now[BYTE_W-1:0];
            sp_q      <= sp_q + SP_W'(1);
            state_q   <= ST_PUSH_HI;
          end
        end
        ST_PUSH_HI: begin
          stk_we    <= 1'b1;
          stk_waddr <= sp_q + SP_W'(1);
          stk_wdata <= pc_hi_q;
          sp_q      <= sp_q + SP_W'(1);
          state_q   <= ST_JUMP;
        end
        ST_JUMP: begin
          redirect_valid <= 1'b1;
          redirect_pc    <= vec_addr;
          state_q        <= ST_IDLE;
        end
        ST_POP_A: begin
          stk_re    <= 1'b1;
          stk_raddr <= sp_q;
          sp_q      <= sp_q - SP_W'(1);
          state_q   <= ST_POP_B;
        end
        ST_POP_B: begin
          pop_hi_q <= stk_rdata;
          state_q  <= ST_POP_C;
        end
        ST_POP_C: begin
          resume_valid <= 1'b1;
          resume_pc    <= {pop_hi_q, stk_rdata};
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_busy = (state_q != ST_IDLE);
  assign sp_now    = sp_q;

  // R3: low-byte write is followed by the high byte one address up
  a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_we) |=> stk_we && (stk_waddr == $past(stk_waddr) + SP_W'(1)));

  // R3: exactly two writes per acceptance
  a_r3_pair_only: assert property (@(posedge clk) disable iff (rst)
    (stk_we && $past(stk_we)) |=> !stk_we);

  // R9: second read is one address below the first
  a_r9_read_down: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_re) |=> stk_re && (stk_raddr == $past(stk_raddr) - SP_W'(1)));

  // R9: reads and writes never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(stk_we && stk_re));

  // R2: redirect is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid);

  // R2: redirect target lies on the vector grid
  a_r2_vector_grid: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (((int'(redirect_pc) - VEC_BASE) % VEC_STEP) == 0) &&
                       (int'(redirect_pc) < VEC_BASE + VEC_STEP * N_SRC));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  irq_req = '0;
  logic        irq_glob_en = 1'b1;
  logic [4:0]  irq_src_en = 5'b11111;
  logic [4:0]  irq_src_hi = '0;
  logic        insn_boundary = 1'b0;
  logic        retn_strobe = 1'b0;
  logic [15:0] pc_now = '0;
  logic        stk_we;
  logic [7:0]  stk_waddr;
  logic [7:0]  stk_wdata;
  logic        stk_re;
  logic [7:0]  stk_raddr;
  logic [7:0]  stk_rdata;
  logic        redirect_valid;
  logic [15:0] redirect_pc;
  logic        resume_valid;
  logic [15:0] resume_pc;
  logic [1:0]  in_service;
  logic        ctrl_busy;
  logic [7:0]  sp_now;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic [7:0] exp_sp = 8'h07;
  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_glob_en(irq_glob_en),
    .irq_src_en(irq_src_en), .irq_src_hi(irq_src_hi),
    .insn_boundary(insn_boundary), .retn_strobe(retn_strobe), .pc_now(pc_now),
    .stk_we(stk_we), .stk_waddr(stk_waddr), .stk_wdata(stk_wdata),
    .stk_re(stk_re), .stk_raddr(stk_raddr), .stk_rdata(stk_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .resume_valid(resume_valid), .resume_pc(resume_pc),
    .in_service(in_service), .ctrl_busy(ctrl_busy), .sp_now(sp_now)
  );

  always @(posedge clk) begin
    if (stk_we) mem[stk_waddr] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_raddr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_accept(input string tag, input logic [15:0] pc, input int src,
                           input logic [1:0] exp_insv);
    logic [7:0] a1 = exp_sp + 8'd1;
    logic [7:0] a2 = exp_sp + 8'd2;
    @(negedge clk); pc_now = pc; insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0;
    chk({tag, " R3 lo we"}, 32'(stk_we), 32'd1);
    chk({tag, " R3 lo addr"}, 32'(stk_waddr), 32'(a1));
    chk({tag, " R3 lo data"}, 32'(stk_wdata), 32'(pc[7:0]));
    @(negedge clk);
    chk({tag, " R3 hi we"}, 32'(stk_we), 32'd1);
    chk({tag, " R3 hi addr"}, 32'(stk_waddr), 32'(a2));
    chk({tag, " R3 hi data"}, 32'(stk_wdata), 32'(pc[15:8]));
    @(negedge clk);
    chk({tag, " R2 redirect valid"}, 32'(redirect_valid), 32'd1);
    chk({tag, " R2 vector"}, 32'(redirect_pc), 32'(3 + 8 * src));
    chk({tag, " R2 in_service"}, 32'(in_service), 32'(exp_insv));
    chk({tag, " R3 sp"}, 32'(sp_now), 32'(a2));
    exp_sp = a2;
    @(negedge clk);
    chk({tag, " R2 pulse end"}, 32'(redirect_valid), 32'd0);
  endtask

  task automatic do_return(input string tag, input logic [15:0] pc,
                           input logic [1:0] exp_insv);
    logic [7:0] top = exp_sp;
    @(negedge clk); retn_strobe = 1'b1;
    @(negedge clk); retn_strobe = 1'b0;
    chk({tag, " R9 first read"}, {23'd0, stk_re, stk_raddr}, {23'd0, 1'b1, top});
    @(negedge clk);
    chk({tag, " R9 second read"}, {23'd0, stk_re, stk_raddr}, {23'd0, 1'b1, top - 8'd1});
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R9 resume valid"}, 32'(resume_valid), 32'd1);
    chk({tag, " R9 resume pc"}, 32'(resume_pc), 32'(pc));
    chk({tag, " R10 in_service"}, 32'(in_service), 32'(exp_insv));
    chk({tag, " R9 sp"}, 32'(sp_now), 32'(top - 8'd2));
    exp_sp = top - 8'd2;
  endtask

  task automatic expect_idle(input string tag, input bit strobe);
    bit seen = 0;
    @(negedge clk); insn_boundary = strobe;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); insn_boundary = 1'b0;
      if (stk_we || redirect_valid) seen = 1;
    end
    chk({tag, " no activity"}, 32'(seen), 32'd0);
    chk({tag, " sp unchanged"}, 32'(sp_now), 32'(exp_sp));
  endtask

  task automatic t_reset();
    chk("R1 sp", 32'(sp_now), 32'h07);
    chk("R1 in_service", 32'(in_service), 32'd0);
    chk("R1 busy", 32'(ctrl_busy), 32'd0);
    chk("R1 strobes", {28'd0, stk_we, stk_re, redirect_valid, resume_valid}, 32'd0);
  endtask

  task automatic t_vectors();
    for (int k = 0; k < 5; k++) begin
      logic [15:0] pc = 16'h1200 + 16'(k * 17);
      irq_req = 5'(1 << k);
      do_accept("R2 vec", pc, k, 2'b01);
      irq_req = '0;
      do_return("R9 vec", pc, 2'b00);
    end
  endtask

  task automatic t_gating();
    irq_req = 5'b00100;
    irq_glob_en = 1'b0;
    expect_idle("R4 global off", 1'b1);
    irq_glob_en = 1'b1;
    irq_src_en = 5'b11011;
    expect_idle("R4 source off", 1'b1);
    irq_src_en = 5'b11111;
    irq_req = '0;
  endtask

  task automatic t_boundary();
    irq_req = 5'b00100;
    expect_idle("R5 no boundary", 1'b0);
    do_accept("R5 with boundary", 16'h0456, 2, 2'b01);
    irq_req = '0;
    do_return("R5 ret", 16'h0456, 2'b00);
  endtask

  task automatic t_order();
    irq_req = 5'b10110;
    do_accept("R6 low order", 16'h2345, 1, 2'b01);
    irq_req = '0;
    do_return("R6 low ret", 16'h2345, 2'b00);
    irq_src_hi = 5'b10100;
    irq_req = 5'b10110;
    do_accept("R6 high order", 16'h3456, 2, 2'b10);
    irq_req = '0;
    do_return("R6 high ret", 16'h3456, 2'b00);
    irq_src_hi = '0;
  endtask

  task automatic t_nesting();
    irq_src_hi = 5'b01000;
    irq_req = 5'b00001;
    do_accept("R7 low entry", 16'hA1B2, 0, 2'b01);
    irq_req = 5'b00011;
    expect_idle("R8 same level blocked", 1'b1);
    irq_req = 5'b01010;
    do_accept("R7 preempt", 16'hC3D4, 3, 2'b11);
    irq_req = 5'b01011;
    expect_idle("R8 high in service blocks", 1'b1);
    irq_req = 5'b00010;
    do_return("R10 leave high", 16'hC3D4, 2'b01);
    expect_idle("R8 low still blocked", 1'b1);
    do_return("R10 leave low", 16'hA1B2, 2'b00);
    do_accept("R10 held request", 16'hE5F6, 1, 2'b01);
    irq_req = '0;
    do_return("R10 final", 16'hE5F6, 2'b00);
    chk("R9 sp back to start", 32'(sp_now), 32'h07);
    irq_src_hi = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_gating();
    t_boundary();
    t_order();
    t_nesting();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule